// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter with Address Marking

This block serializes bytes onto an asynchronous serial line. The frame layout is set by a format byte: data width, one or two stop bits, parity on or off with odd or even sense, and an optional address/data marker bit for multi-drop buses. Software writes bytes into a small transmit queue. The serializer drains that queue at a bit rate set by a 16-bit divider, and sends frames back to back while bytes are waiting.

On a multi-drop bus every frame carries a marker bit in address-marker mode. To send an address frame, the caller pulses `wake_set` before writing the byte. The flag attaches to the next accepted byte only, so the frames after it go out as data frames. The format byte is read again at the start of each frame, so a change takes effect on the next frame without disturbing the current one.

Top module: `async_tx_top`

## Requirements
- R1: After reset, `tx_line` is 1 (idle) and `buf_free` is 1.
- R2: A frame starts with one bit at 0, then carries `ctrl_byte[2:0]`+1 data bits (1 to 8), least significant bit first; unused upper data bits are not sent.
- R3: `ctrl_byte[7]` = 0 ends the frame with one stop bit at 1; `ctrl_byte[7]` = 1 ends it with two.
- R4: With `ctrl_byte[5]` = 1 a parity bit follows the data and the marker bit. It makes the count of ones over data, marker and parity even when `ctrl_byte[6]` = 1 and odd when `ctrl_byte[6]` = 0. With `ctrl_byte[5]` = 0 there is no parity bit.
- R5: With `ctrl_byte[3]` = 1 one marker bit follows the last data bit: 1 for an address frame, 0 for a data frame. With `ctrl_byte[3]` = 0 no marker bit is sent. `ctrl_byte[4]` has no effect on the line.
- R6: A `wake_set` pulse at or before a write marks the next accepted byte as an address frame. Only that byte is marked; later bytes are data frames.
- R7: Each bit lasts (`baud_div`+1)×8 clock cycles.
- R8: The queue holds DEPTH bytes. `buf_free` is 0 while it is full, and a write while it is full is dropped.
- R9: The format is taken from `ctrl_byte` when a frame starts. A change during a frame affects only later frames.
- R10: When a byte is waiting, the next start bit follows the last stop bit directly, with no extra idle time. Between frames with nothing queued the line stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_byte | input | 8 | Frame format: [7] two stops, [6] even parity, [5] parity on, [4] no effect, [3] marker mode, [2:0] data bits minus one |
| baud_div | input | DIV_W | Bit period divider; a bit lasts (value+1)×8 cycles |
| wr_data | input | 8 | Byte to queue |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wake_set | input | 1 | Marks the next accepted byte as an address frame |
| tx_line | output | 1 | Serial output, idles high |
| buf_free | output | 1 | High while the queue can accept a byte |

## Verification
The checker assumes that `baud_div` stays constant while a frame is on the line and that writes arrive as single-cycle strobes. It also assumes that `wake_set` is pulsed only to mark the byte written next. The bench changes the divider only when the line is idle. It drives the strobes from the falling clock edge, one byte per cycle at most. Only the format byte changes during a frame, and only in the test that checks the frame-start sampling rule.

// File: rtl/async_tx_pkg.sv
`timescale 1ns/1ps
package async_tx_pkg;

  localparam int DATA_MAX = 8;
  localparam int FRAME_W  = 13;   // start + 8 data + marker + parity + 2 stop
  localparam int NBITS_W  = 4;

  typedef struct packed {
    logic       two_stop;
    logic       par_even;
    logic       par_on;
    logic       spare;
    logic       mark_mode;
    logic [2:0] len_m1;
  } tx_fmt_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [NBITS_W-1:0] nbits;
  } frame_t;

  typedef struct packed {
    logic       mark;
    logic [7:0] data;
  } q_entry_t;

  function automatic frame_t build_frame(input tx_fmt_t f, input logic [7:0] d,
                                         input logic mark);
    frame_t r;
    logic [NBITS_W-1:0] pos;
    logic ones;
    r.bits    = '1;
    r.bits[0] = 1'b0;
    pos  = NBITS_W'(1);
    ones = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i <= int'(f.len_m1)) begin
        r.bits[pos] = d[i];
        ones = ones ^ d[i];
        pos  = pos + NBITS_W'(1);
      end
    end
    if (f.mark_mode) begin
      r.bits[pos] = mark;
      ones = ones ^ mark;
      pos  = pos + NBITS_W'(1);
    end
    if (f.par_on) begin
      r.bits[pos] = f.par_even ? ones : ~ones;
      pos  = pos + NBITS_W'(1);
    end
    r.nbits = pos + NBITS_W'(1) + NBITS_W'(f.two_stop);
    return r;
  endfunction

endpackage

// File: rtl/tx_queue.sv
`timescale 1ns/1ps
module tx_queue #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (fill == '0);
  assign full    = (fill == FW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + FW'(1);
        2'b01:   fill <= fill - FW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/tx_bit_timer.sv
`timescale 1ns/1ps
module tx_bit_timer #(
  parameter int DIV_W = 16,
  parameter int OVS   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = DIV_W + $clog2(OVS) + 1;

  logic [CW-1:0] cnt, limit, div_ext;

  assign div_ext = CW'(div);
  assign limit   = (div_ext + CW'(1)) * CW'(OVS) - CW'(1);
  assign tick    = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear || tick) cnt <= '0;
    else                      cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/tx_serializer.sv
`timescale 1ns/1ps
module tx_serializer
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       have_data,
  input  q_entry_t   head,
  input  tx_fmt_t    fmt,
  output logic       pop,
  output logic       busy,
  output logic       timer_clear,
  output logic       line
);
  logic [FRAME_W-1:0] shreg;
  logic [NBITS_W-1:0] left;
  logic               last_bit_end;
  frame_t             nxt;

  assign last_bit_end = busy && tick && (left == NBITS_W'(1));
  assign pop          = have_data && (!busy || last_bit_end);
  assign timer_clear  = pop || !busy;
  assign nxt          = build_frame(fmt, head.data, head.mark);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      line  <= 1'b1;
      shreg <= '1;
      left  <= '0;
    end else if (pop) begin
      busy  <= 1'b1;
      line  <= nxt.bits[0];
      shreg <= {1'b1, nxt.bits[FRAME_W-1:1]};
      left  <= nxt.nbits;
    end else if (busy && tick) begin
      if (left == NBITS_W'(1)) begin
        busy <= 1'b0;
        line <= 1'b1;
      end else begin
        line  <= shreg[0];
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - NBITS_W'(1);
      end
    end
  end
endmodule

// File: rtl/async_tx_top.sv
`timescale 1ns/1ps
module async_tx_top
  import async_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIV_W = 16,
  parameter int OVS   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       ctrl_byte,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [7:0]       wr_data,
  input  logic             wr_en,
  input  logic             wake_set,
  output logic             tx_line,
  output logic             buf_free
);
  localparam int FW = $clog2(DEPTH+1);

  logic          wake_pend;
  logic          q_full, q_empty, q_pop;
  logic [FW-1:0] fill_cnt;
  q_entry_t      q_in, q_head;
  logic          tick, t_clear, ser_busy;
  logic          accept;

  assign accept    = wr_en && !q_full;
  assign q_in.data = wr_data;
  assign q_in.mark = wake_pend || wake_set;
  assign buf_free  = !q_full;

  always_ff @(posedge clk) begin
    if (rst)         wake_pend <= 1'b0;
    else if (accept) wake_pend <= 1'b0;
    else if (wake_set) wake_pend <= 1'b1;
  end

  tx_queue #(.W($bits(q_entry_t)), .DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst(rst),
    .push(wr_en), .push_data(q_in),
    .pop(q_pop), .head(q_head),
    .empty(q_empty), .full(q_full), .fill(fill_cnt)
  );

  tx_bit_timer #(.DIV_W(DIV_W), .OVS(OVS)) timer_i (
    .clk(clk), .rst(rst), .clear(t_clear), .div(baud_div), .tick(tick)
  );

  tx_serializer ser_i (
    .clk(clk), .rst(rst), .tick(tick),
    .have_data(!q_empty), .head(q_head), .fmt(tx_fmt_t'(ctrl_byte)),
    .pop(q_pop), .busy(ser_busy), .timer_clear(t_clear), .line(tx_line)
  );
endmodule

// File: rtl/async_tx_chk.sv
`timescale 1ns/1ps
module async_tx_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic                       tx_line,
  input logic                       buf_free,
  input logic                       busy,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tx_line && buf_free));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (!buf_free && wr_en) |=> (fill <= $past(fill)));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx_line);

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);
endmodule

bind async_tx_top async_tx_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .tx_line(tx_line),
  .buf_free(buf_free), .busy(ser_busy), .fill(fill_cnt)
);

// File: tb/async_tx_top_tb_top.sv
`timescale 1ns/1ps
module async_tx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ctrl_byte = 8'h07;
  logic [15:0] baud_div = 16'd0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_en = 1'b0;
  logic       wake_set = 1'b0;
  logic       tx_line, buf_free;

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_tx_top dut_i (
    .clk(clk), .rst(rst), .ctrl_byte(ctrl_byte), .baud_div(baud_div),
    .wr_data(wr_data), .wr_en(wr_en), .wake_set(wake_set),
    .tx_line(tx_line), .buf_free(buf_free)
  );

  // {ctrl, div, data, wake}
  localparam logic [32:0] VEC [9] = '{
    {8'h07, 16'd0, 8'hA5, 1'b0},
    {8'h87, 16'd1, 8'h3C, 1'b0},
    {8'h27, 16'd0, 8'h01, 1'b0},
    {8'h67, 16'd0, 8'h03, 1'b0},
    {8'h16, 16'd0, 8'hFF, 1'b0},
    {8'h00, 16'd2, 8'h02, 1'b0},
    {8'h0F, 16'd0, 8'h55, 1'b1},
    {8'h2B, 16'd1, 8'h09, 1'b0},
    {8'hEA, 16'd0, 8'h07, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [7:0] c, input logic [7:0] d,
                                    input logic mk, output logic [15:0] b,
                                    output int n);
    int ones;
    b = '1;
    b[0] = 1'b0;
    n = 1;
    ones = 0;
    for (int i = 0; i <= int'(c[2:0]); i++) begin
      b[n] = d[i];
      ones += int'(d[i]);
      n++;
    end
    if (c[3]) begin
      b[n] = mk;
      ones += int'(mk);
      n++;
    end
    if (c[5]) begin
      b[n] = c[6] ? ((ones % 2) == 1) : ((ones % 2) == 0);
      n++;
    end
    n += c[7] ? 2 : 1;
  endfunction

  task automatic get_frame(input int p, input int nb, output logic [15:0] bits);
    int t = 0;
    bits = '1;
    while (tx_line !== 1'b0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (p / 2) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      bits[k] = tx_line;
      if (k < nb - 1) repeat (p) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic wk);
    @(negedge clk);
    wake_set = wk;
    @(negedge clk);
    wake_set = 1'b0;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic burst(input int cnt, input logic [7:0] base);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      wr_data = base + 8'(i);
      wr_en = 1'b1;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_frame(input logic [7:0] c, input int p, input logic [7:0] d,
                              input logic mk, input string tag);
    logic [15:0] eb, got;
    int n;
    exp_frame(c, d, mk, eb, n);
    get_frame(p, n, got);
    chk(got == eb, tag, 32'(got), 32'(eb));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tx_line === 1'b1, "R1 idle line after reset", 32'(tx_line), 1);
    chk(buf_free === 1'b1, "R1 buf_free after reset", 32'(buf_free), 1);

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 9; v++) begin
      logic [7:0] c, d;
      logic [15:0] dv;
      logic wk;
      logic [15:0] eb, got;
      int n, p;
      {c, dv, d, wk} = VEC[v];
      ctrl_byte = c;
      baud_div = dv;
      p = (int'(dv) + 1) * 8;
      exp_frame(c, d, wk, eb, n);
      send(d, wk);
      get_frame(p, n, got);
      chk(got == eb, $sformatf("vector %0d frame bits (R2,R3,R4,R5,R7)", v),
          32'(got), 32'(eb));
      repeat (p) @(negedge clk);
      chk(tx_line === 1'b1, $sformatf("vector %0d length, R3 R5 idle after frame", v),
          32'(tx_line), 1);
    end

    // R6: marker applies to one frame only
    ctrl_byte = 8'h0F;
    baud_div = 16'd0;
    fork
      begin send(8'h11, 1'b1); send(8'h22, 1'b0); send(8'h33, 1'b0); end
      begin
        expect_frame(8'h0F, 8, 8'h11, 1'b1, "R6 address frame");
        expect_frame(8'h0F, 8, 8'h22, 1'b0, "R6 next frame is data");
        expect_frame(8'h0F, 8, 8'h33, 1'b0, "R6 third frame is data");
      end
    join
    repeat (200) @(negedge clk);

    // R7: start bit length in cycles
    ctrl_byte = 8'h07;
    baud_div = 16'd2;
    begin
      int lo = 0;
      send(8'h01, 1'b0);
      while (tx_line !== 1'b0) @(negedge clk);
      while (tx_line === 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
      chk(lo == 24, "R7 start bit cycles", 32'(lo), 24);
    end
    repeat (300) @(negedge clk);

    // R10: back-to-back frames, spacing equals frame length
    baud_div = 16'd0;
    begin
      int t1 = 0, t2 = 0;
      burst(2, 8'hFE);
      while (tx_line !== 1'b0) @(negedge clk);
      t1 = cyc;
      repeat (76) @(negedge clk);
      while (tx_line !== 1'b0 && cyc < t1 + 200) @(negedge clk);
      t2 = cyc;
      chk(t2 - t1 == 80, "R10 start-to-start spacing", 32'(t2 - t1), 80);
    end
    repeat (200) @(negedge clk);
    chk(tx_line === 1'b1, "R10 line idle after drain", 32'(tx_line), 1);

    // R8: queue full, extra write dropped
    baud_div = 16'd3;
    fork
      begin
        burst(6, 8'h40);
        chk(buf_free === 1'b0, "R8 buf_free low when full", 32'(buf_free), 0);
      end
      begin
        for (int i = 0; i < 5; i++)
          expect_frame(8'h07, 32, 8'h40 + 8'(i), 1'b0,
                       $sformatf("R8 queued frame %0d", i));
        begin
          int lows = 0;
          repeat (400) begin
            @(negedge clk);
            if (tx_line !== 1'b1) lows++;
          end
          chk(lows == 0, "R8 dropped byte never sent", 32'(lows), 0);
        end
        chk(buf_free === 1'b1, "R8 buf_free after drain", 32'(buf_free), 1);
      end
    join

    // R9: format change during a frame applies to the next frame only
    ctrl_byte = 8'h07;
    baud_div = 16'd0;
    fork
      burst(2, 8'h5A);
      begin
        while (tx_line !== 1'b0) @(negedge clk);
        repeat (3) @(negedge clk);
        ctrl_byte = 8'hA3;
      end
      begin
        expect_frame(8'h07, 8, 8'h5A, 1'b0, "R9 frame keeps old format");
        expect_frame(8'hA3, 8, 8'h5B, 1'b0, "R9 next frame uses new format");
      end
    join
    repeat (100) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule